// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous memory core during a four-beat burst. When either of two active-low address strobes is sampled low, the external address is captured as the burst start and a beat counter is cleared. On later edges, with both strobes high and the active-low advance input low, the counter steps. With advance high, the address holds.

The two least significant address bits follow one of two orders, chosen by a static order-select input. In interleaved order each beat is the start bits XOR the beat count. In linear order each beat is the start bits plus the beat count, modulo four. Bits above the low field never change within a burst. After the fourth beat, further advances run through the same four addresses again. A strobe reloads the sequencer at any point in a burst.

The advance rule is the same for read and write bursts: the address steps whenever advance is sampled low while no strobe is active. The write decode that accompanies a write burst is left to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after reset until the first load, cur_addr is all zeros.
- R2: When strb_proc_n or strb_ctrl_n (or both) is sampled low at a rising edge, cur_addr equals ext_addr from the cycle after that edge.
- R3: adv_n has no effect on an edge where either strobe is sampled low. The loaded address is the unmodified ext_addr.
- R4: cur_addr changes only when adv_n is sampled low with both strobes high. With adv_n high and both strobes high, cur_addr holds.
- R5: With order_sel = 1 (interleaved), beat k of the burst has low bits equal to the start bits XOR k. A start of 01 runs 01, 00, 11, 10, and a start of 10 runs 10, 11, 00, 01.
- R6: With order_sel = 0 (linear), beat k has low bits equal to (start bits + k) mod 4. A start of 01 runs 01, 10, 11, 00, and a start of 11 runs 11, 00, 01, 10.
- R7: Bits above the two low bits keep their loaded value for the whole burst, including when the low field wraps from 11 to 00.
- R8: The advance after the fourth beat returns to the start address and repeats the same order.
- R9: A strobe in the middle of a burst loads the new address and restarts the beat count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 1 | Burst order: 1 selects interleaved, 0 selects linear |
| strb_proc_n | input | 1 | Active-low load strobe (processor side) |
| strb_ctrl_n | input | 1 | Active-low load strobe (controller side) |
| adv_n | input | 1 | Active-low burst advance |
| ext_addr | input | AW (19) | External address, captured on a load |
| cur_addr | output | AW (19) | Current burst address to the memory core |

## Verification
A load and an advance request can both fall on one edge. The bench provokes this by holding adv_n low while either strobe, or both, is low, both at the start of a burst and halfway through one. The scoreboard expects exactly the new external address on the next cycle, with no step applied. It then expects the next advance to produce beat one of the new burst. A stepped or stale value shows that advance won, or that the beat count survived the reload.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 19,
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          order_sel,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr
);
  localparam logic [LB-1:0] ONE = LB'(1);

  logic [AW-1:0] start_q;
  logic [LB-1:0] beat_q;
  logic          load, step;
  logic [LB-1:0] low_ilv, low_lin;

  assign load = !strb_proc_n || !strb_ctrl_n;
  assign step = !load && !adv_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= ext_addr;
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_q + ONE;
    end
  end

  assign low_ilv  = start_q[LB-1:0] ^ beat_q;
  assign low_lin  = start_q[LB-1:0] + beat_q;
  assign cur_addr = {start_q[AW-1:LB], order_sel ? low_ilv : low_lin};
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 19,
  parameter int LB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          order_sel,
  input logic          strb_proc_n,
  input logic          strb_ctrl_n,
  input logic          adv_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] cur_addr
);
  localparam logic [LB-1:0] ONE = LB'(1);

  always_comb
    if (!rst_n) assert_reset_zero_R1: assert (cur_addr == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n || !strb_ctrl_n) |=> cur_addr == $past(ext_addr));

  assert_adv_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_proc_n || !strb_ctrl_n) && !adv_n) |=> cur_addr == $past(ext_addr));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && strb_ctrl_n && adv_n) |=> ($stable(cur_addr) || !$stable(order_sel)));

  assert_ilv_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && strb_ctrl_n && !adv_n && order_sel) |=>
      (!order_sel || $countones(cur_addr[LB-1:0] ^ $past(cur_addr[LB-1:0])) >= 1));

  assert_lin_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && strb_ctrl_n && !adv_n && !order_sel) |=>
      (order_sel || cur_addr[LB-1:0] == $past(cur_addr[LB-1:0]) + ONE));

  assert_upper_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && strb_ctrl_n) |=> cur_addr[AW-1:LB] == $past(cur_addr[AW-1:LB]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .LB(LB)) u_chk (
  .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .strb_proc_n(strb_proc_n),
  .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .ext_addr(ext_addr), .cur_addr(cur_addr)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 19;

  logic clk = 0, rst_n = 0, order_sel = 1, strb_proc_n = 1, strb_ctrl_n = 1, adv_n = 1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  bit            done = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.AW(AW), .LB(2)) u0 (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .strb_proc_n(strb_proc_n),
    .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .ext_addr(ext_addr), .cur_addr(cur_addr)
  );

  task automatic cyc(input logic p, input logic c, input logic a,
                     input logic [AW-1:0] ad, input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    strb_proc_n = p; strb_ctrl_n = c; adv_n = a; ext_addr = ad;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (cur_addr !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, cur_addr, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cur_addr !== '0) begin fails++; $display("FAIL R1 reset: got %h expected 0", cur_addr); end
    @(negedge clk); rst_n = 1;
    cyc(1, 1, 1, 19'h12345, 19'h00000, "R1 no load after reset");

    order_sel = 1;
    cyc(0, 1, 0, 19'h2B3C1, 19'h2B3C1, "R3 adv ignored on proc load");
    cyc(1, 1, 0, 19'h0, 19'h2B3C0, "R5 ilv beat1");
    cyc(1, 1, 0, 19'h0, 19'h2B3C3, "R5 ilv beat2");
    cyc(1, 1, 0, 19'h0, 19'h2B3C2, "R5 ilv beat3");
    cyc(1, 1, 0, 19'h0, 19'h2B3C1, "R8 ilv wrap to start");
    cyc(1, 1, 1, 19'h0, 19'h2B3C1, "R4 hold");
    cyc(1, 1, 0, 19'h0, 19'h2B3C0, "R8 ilv repeat beat1");
    cyc(1, 1, 1, 19'h0, 19'h2B3C0, "R4 hold again");
    cyc(1, 0, 0, 19'h7FFE2, 19'h7FFE2, "R2 ctrl load with adv low");
    cyc(1, 1, 0, 19'h0, 19'h7FFE3, "R5 ilv start10 beat1");
    cyc(1, 1, 0, 19'h0, 19'h7FFE0, "R7 ilv start10 beat2");
    cyc(1, 1, 0, 19'h0, 19'h7FFE1, "R5 ilv start10 beat3");

    order_sel = 0;
    cyc(1, 0, 1, 19'h10001, 19'h10001, "R2 ctrl load linear");
    cyc(1, 1, 0, 19'h0, 19'h10002, "R6 lin beat1");
    cyc(1, 1, 0, 19'h0, 19'h10003, "R6 lin beat2");
    cyc(1, 1, 0, 19'h0, 19'h10000, "R7 lin beat3 upper kept");
    cyc(1, 1, 0, 19'h0, 19'h10001, "R8 lin wrap to start");
    cyc(0, 0, 0, 19'h1FFFF, 19'h1FFFF, "R2 both strobes load");
    cyc(1, 1, 0, 19'h0, 19'h1FFFC, "R7 lin 11->00 upper kept");
    cyc(1, 1, 0, 19'h0, 19'h1FFFD, "R6 lin start11 beat2");
    cyc(1, 1, 1, 19'h0, 19'h1FFFD, "R4 lin hold");
    cyc(1, 1, 0, 19'h0, 19'h1FFFE, "R6 lin start11 beat3");
    cyc(1, 0, 1, 19'h00100, 19'h00100, "R2 load for reload test");
    cyc(1, 1, 0, 19'h0, 19'h00101, "R6 beat1 before reload");
    cyc(0, 1, 0, 19'h00102, 19'h00102, "R9 mid-burst reload adv low");
    cyc(1, 1, 0, 19'h0, 19'h00103, "R9 count restarted");
    cyc(1, 1, 1, 19'h0, 19'h00103, "R4 hold after reload");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule